// File: doc/BRIEF.md
# Word Load/Store Unit with Base Autoupdate

This block carries out word-sized memory operations for a small 32-bit register-machine datapath. A request supplies a base register value, a signed 16-bit displacement, store data, the register indices of the destination and of the base, and an operation: load word, store word, or load word with base update. The unit sign-extends the displacement and adds it to the base to form a byte address. It then reads or writes an internal word-addressed data memory and hands back up to two register write-backs in one cycle, marked by a done pulse.

The autoupdate load returns the memory word on the first write-back port. It returns the computed address on the second port, aimed at the base register, so that a pointer walking an array can advance in the same operation that fetches each element. Writes to register 0 are dropped because that register always reads as zero. When the destination and the base name the same register, the loaded word wins. A byte address whose two low bits are not zero is flagged as misaligned, and the operation then neither touches memory nor writes any register.

The controller is a three-state machine. In `IDLE` it holds `req_ready` high, and an accepted request moves it to `ACCESS`. In `ACCESS` it issues the memory read or write, or suppresses it when the address is misaligned, and always moves on to `FINISH`. In `FINISH` it raises `done` with the write-back values for one cycle and always returns to `IDLE`.

Top module: `lsu_autoupd`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits, computed modulo 2^32 (a negative displacement subtracts).
- R2: A load word (`req_op` = 2'b00) drives `wb0_en`=1, `wb0_idx`=`req_dst_idx` and `wb0_data` = the memory word at the effective address, with `wb1_en`=0. `done` is high in the second cycle after the accepting clock edge.
- R3: A store word (`req_op` = 2'b01) writes `req_wdata` into the memory word at the effective address and raises `done` with `wb0_en`=0 and `wb1_en`=0.
- R4: A load with update (`req_op` = 2'b10) returns the memory word on port 0 to `req_dst_idx`, and returns the effective address on port 1 (`wb1_data`) to `req_base_idx`, both in the same done cycle.
- R5: No write-back port is ever enabled with register index 0. A load to register 0 or an update of base register 0 drops that write-back, and any other write-back of the same operation still takes place.
- R6: When a load with update names the same register as destination and base, only the loaded word is written (`wb0_en`=1, `wb1_en`=0).
- R7: When the effective address has a nonzero value in bits [1:0], `misalign` is high together with `done`, both write-back enables stay low, and memory is not written.
- R8: `req_ready` is high only in `IDLE`. It falls for the two cycles after an accepted request, and a request presented during those cycles is neither accepted nor applied.
- R9: After reset `req_ready`=1 and `done`, `misalign`, `wb0_en` and `wb1_en` are all 0.
- R10: The memory holds 256 words indexed by address bits [9:2]. Address bits above bit 9 are ignored, so addresses 1024 bytes apart name the same word.
- R11: The reserved operation code 2'b11 completes with a done pulse, `misalign` low, no write-back, and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | 00 load, 01 store, 10 load with update, 11 reserved |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data |
| req_dst_idx | input | 5 | Destination register index |
| req_base_idx | input | 5 | Base register index |
| done | output | 1 | Write-back values valid this cycle |
| misalign | output | 1 | Operation rejected for misalignment (with done) |
| wb0_en | output | 1 | Write loaded data |
| wb0_idx | output | 5 | Register for loaded data |
| wb0_data | output | 32 | Loaded data |
| wb1_en | output | 1 | Write updated base |
| wb1_idx | output | 5 | Register for updated base |
| wb1_data | output | 32 | Updated base (effective address) |

## Verification
On every cycle, the embedded assertions enforce the handshake timing (ready drops after acceptance and done follows exactly two edges later as a single-cycle pulse). They also enforce that no write-back targets register 0, that the two ports never name the same register, that a misaligned operation enables no write-back, and that memory is never written at a misaligned address. The data itself can only be shown by the directed scenarios: the sign-extended address sum and its wrap, the word returned by a load after a store, the base value written by an autoupdate walk, the aliasing above bit 9, and the proof that a misaligned, reserved or busy-time store left memory unchanged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        OP_LW  = 2'b00,
        OP_SW  = 2'b01,
        OP_LWU = 2'b10,
        OP_RSV = 2'b11
    } lsu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACCESS = 2'b01,
        ST_FINISH = 2'b10
    } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   ea,
    output logic              unaligned
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_ext;

    always_comb begin
        disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea        = base + disp_ext;
        unaligned = (ea[1:0] != 2'b00);
    end
endmodule

// File: rtl/lsu_dmem.sv
module lsu_dmem #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata
);
    logic [XLEN-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[idx] <= wdata;
        end
        if (re) begin
            rdata <= store_q[idx];
        end
    end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
    import lsu_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [RIDX_W-1:0] req_dst_idx,
    input  logic [RIDX_W-1:0] req_base_idx,
    input  logic              unaligned_q,
    output logic              accept,
    output logic              mem_we,
    output logic              mem_re,
    output logic              done,
    output logic              misalign,
    output logic              wb0_en,
    output logic [RIDX_W-1:0] wb0_idx,
    output logic              wb1_en,
    output logic [RIDX_W-1:0] wb1_idx
);
    lsu_state_e state_q, state_d;
    lsu_op_e    op_q;
    logic       is_load;

    assign accept  = req_valid && req_ready;
    assign is_load = (op_q == OP_LW) || (op_q == OP_LWU);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_RSV;
            wb0_idx <= '0;
            wb1_idx <= '0;
        end else if (accept) begin
            op_q    <= lsu_op_e'(req_op);
            wb0_idx <= req_dst_idx;
            wb1_idx <= req_base_idx;
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        done      = 1'b0;
        misalign  = 1'b0;
        wb0_en    = 1'b0;
        wb1_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                mem_re  = !unaligned_q && is_load;
                mem_we  = !unaligned_q && (op_q == OP_SW);
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done     = 1'b1;
                misalign = unaligned_q && (op_q != OP_RSV);
                wb0_en   = !unaligned_q && is_load && (wb0_idx != '0);
                wb1_en   = !unaligned_q && (op_q == OP_LWU)
                           && (wb1_idx != '0) && (wb1_idx != wb0_idx);
                state_d  = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 done);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_no_zero_wb0: assert property (@(posedge clk) disable iff (!rst_n)
        wb0_en |-> (wb0_idx != '0));
    a_r5_no_zero_wb1: assert property (@(posedge clk) disable iff (!rst_n)
        wb1_en |-> (wb1_idx != '0));
    a_r6_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en && wb1_en) |-> (wb0_idx != wb1_idx));
    a_r7_no_wb_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (done && !wb0_en && !wb1_en));
endmodule

// File: rtl/lsu_autoupd.sv
module lsu_autoupd #(
    parameter int XLEN      = 32,
    parameter int DISP_W    = 16,
    parameter int RIDX_W    = 5,
    parameter int MEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [XLEN-1:0]   req_base,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic [RIDX_W-1:0] req_dst_idx,
    input  logic [RIDX_W-1:0] req_base_idx,
    output logic              done,
    output logic              misalign,
    output logic              wb0_en,
    output logic [RIDX_W-1:0] wb0_idx,
    output logic [XLEN-1:0]   wb0_data,
    output logic              wb1_en,
    output logic [RIDX_W-1:0] wb1_idx,
    output logic [XLEN-1:0]   wb1_data
);
    localparam int MIDX_W = $clog2(MEM_WORDS);

    logic [XLEN-1:0] ea_c, ea_q, wdata_q, rdata;
    logic            unaligned_c, unaligned_q;
    logic            accept, mem_we, mem_re;

    lsu_agen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_agen (
        .base      (req_base),
        .disp      (req_disp),
        .ea        (ea_c),
        .unaligned (unaligned_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q        <= '0;
            wdata_q     <= '0;
            unaligned_q <= 1'b0;
        end else if (accept) begin
            ea_q        <= ea_c;
            wdata_q     <= req_wdata;
            unaligned_q <= unaligned_c;
        end
    end

    lsu_ctrl #(.RIDX_W(RIDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_op       (req_op),
        .req_dst_idx  (req_dst_idx),
        .req_base_idx (req_base_idx),
        .unaligned_q  (unaligned_q),
        .accept       (accept),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .done         (done),
        .misalign     (misalign),
        .wb0_en       (wb0_en),
        .wb0_idx      (wb0_idx),
        .wb1_en       (wb1_en),
        .wb1_idx      (wb1_idx)
    );

    lsu_dmem #(.XLEN(XLEN), .DEPTH(MEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .idx   (ea_q[MIDX_W+1:2]),
        .wdata (wdata_q),
        .rdata (rdata)
    );

    assign wb0_data = done ? rdata : '0;
    assign wb1_data = done ? ea_q  : '0;

    a_r7_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (ea_q[1:0] == 2'b00));
    a_r4_wb1_is_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wb1_en |-> (wb1_data[1:0] == 2'b00));
endmodule

// File: tb/lsu_autoupd_test.sv
module lsu_autoupd_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_base = '0;
    logic [15:0] req_disp = '0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  req_dst_idx = '0;
    logic [4:0]  req_base_idx = '0;
    logic        done, misalign, wb0_en, wb1_en;
    logic [4:0]  wb0_idx, wb1_idx;
    logic [31:0] wb0_data, wb1_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [256];

    logic        o_done, o_mis, o_en0, o_en1, o_busy_ready;
    logic [4:0]  o_idx0, o_idx1;
    logic [31:0] o_d0, o_d1;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_autoupd uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_base(req_base), .req_disp(req_disp),
        .req_wdata(req_wdata), .req_dst_idx(req_dst_idx), .req_base_idx(req_base_idx),
        .done(done), .misalign(misalign), .wb0_en(wb0_en), .wb0_idx(wb0_idx),
        .wb0_data(wb0_data), .wb1_en(wb1_en), .wb1_idx(wb1_idx), .wb1_data(wb1_data)
    );

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] d);
        return b + {{16{d[15]}}, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] b, input logic [15:0] d,
                          input logic [31:0] wd, input logic [4:0] dst, input logic [4:0] bi);
        logic [31:0] ea;
        @(negedge clk);
        req_op = op; req_base = b; req_disp = d; req_wdata = wd;
        req_dst_idx = dst; req_base_idx = bi; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        o_busy_ready = req_ready;
        @(posedge clk);
        @(negedge clk);
        o_done = done; o_mis = misalign; o_en0 = wb0_en; o_en1 = wb1_en;
        o_idx0 = wb0_idx; o_idx1 = wb1_idx; o_d0 = wb0_data; o_d1 = wb1_data;
        ea = ea_of(b, d);
        if (op == 2'b01 && ea[1:0] == 2'b00) model[ea[9:2]] = wd;
    endtask

    task automatic t_reset;
        chk("R9 ready", {31'b0, req_ready}, 32'd1);
        chk("R9 done", {31'b0, done}, 32'd0);
        chk("R9 misalign", {31'b0, misalign}, 32'd0);
        chk("R9 wb enables", {30'b0, wb0_en, wb1_en}, 32'd0);
    endtask

    task automatic t_store_load;
        run_op(2'b01, 32'h0000_1000, 16'h0008, 32'hA5A5_0001, 5'd3, 5'd4);
        chk("R3 store done", {31'b0, o_done}, 32'd1);
        chk("R3 store no wb", {30'b0, o_en0, o_en1}, 32'd0);
        chk("R8 busy ready low", {31'b0, o_busy_ready}, 32'd0);
        run_op(2'b00, 32'h0000_1010, 16'hFFF8, 32'h0, 5'd7, 5'd4);
        chk("R2 load done", {31'b0, o_done}, 32'd1);
        chk("R1 R2 negative disp data", o_d0, 32'hA5A5_0001);
        chk("R2 load wb0 en/idx", {26'b0, o_en0, o_idx0}, {26'b0, 1'b1, 5'd7});
        chk("R2 load no wb1", {31'b0, o_en1}, 32'd0);
    endtask

    task automatic t_autoupdate_walk;
        for (int i = 0; i < 4; i++)
            run_op(2'b01, 32'h0000_0200, 16'(4 * i), 32'h100 + 32'(i), 5'd1, 5'd2);
        for (int i = 0; i < 4; i++) begin
            run_op(2'b10, 32'h0000_01FC + 32'(4 * i), 16'h0004, 32'h0, 5'd9, 5'd8);
            chk("R4 walk data", o_d0, model[8'(32'h80 + 32'(i))]);
            chk("R4 walk new base", o_d1, 32'h0000_0200 + 32'(4 * i));
            chk("R4 both enables", {24'b0, o_en0, o_en1, o_idx0, 1'b0},
                {24'b0, 1'b1, 1'b1, 5'd9, 1'b0});
            chk("R4 wb1 idx", {27'b0, o_idx1}, 32'd8);
        end
    endtask

    task automatic t_zero_reg;
        run_op(2'b00, 32'h0000_0200, 16'h0, 32'h0, 5'd0, 5'd5);
        chk("R5 load to r0 dropped", {31'b0, o_en0}, 32'd0);
        chk("R5 load to r0 done", {31'b0, o_done}, 32'd1);
        run_op(2'b10, 32'h0000_0200, 16'h0004, 32'h0, 5'd6, 5'd0);
        chk("R5 update of r0 dropped", {31'b0, o_en1}, 32'd0);
        chk("R5 data still written", {31'b0, o_en0}, 32'd1);
        chk("R5 data value", o_d0, model[8'h81]);
    endtask

    task automatic t_same_reg;
        run_op(2'b10, 32'h0000_0200, 16'h0008, 32'h0, 5'd12, 5'd12);
        chk("R6 data wins en", {31'b0, o_en0}, 32'd1);
        chk("R6 update suppressed", {31'b0, o_en1}, 32'd0);
        chk("R6 data value", o_d0, model[8'h82]);
    endtask

    task automatic t_misalign;
        run_op(2'b01, 32'h0000_1006, 16'h0004, 32'hDEAD_BEEF, 5'd1, 5'd2);
        chk("R7 store flag", {30'b0, o_done, o_mis}, 32'd3);
        chk("R7 store no wb", {30'b0, o_en0, o_en1}, 32'd0);
        run_op(2'b10, 32'h0000_1000, 16'h0009, 32'h0, 5'd3, 5'd4);
        chk("R7 update flag", {31'b0, o_mis}, 32'd1);
        chk("R7 update no wb", {30'b0, o_en0, o_en1}, 32'd0);
        run_op(2'b00, 32'h0000_1008, 16'h0, 32'h0, 5'd3, 5'd4);
        chk("R7 memory untouched", o_d0, 32'hA5A5_0001);
        chk("R7 aligned no flag", {31'b0, o_mis}, 32'd0);
    endtask

    task automatic t_alias_wrap;
        run_op(2'b01, 32'h0000_0400, 16'h0020, 32'h5151_5151, 5'd1, 5'd2);
        run_op(2'b00, 32'h0000_0000, 16'h0020, 32'h0, 5'd10, 5'd2);
        chk("R10 alias above bit 9", o_d0, 32'h5151_5151);
        run_op(2'b10, 32'hFFFF_FFFC, 16'h0024, 32'h0, 5'd10, 5'd11);
        chk("R1 wrap address", o_d1, 32'h0000_0020);
        chk("R1 wrap data", o_d0, 32'h5151_5151);
    endtask

    task automatic t_busy;
        @(negedge clk);
        req_op = 2'b00; req_base = 32'h1008; req_disp = 16'h0;
        req_dst_idx = 5'd5; req_base_idx = 5'd6; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 ready low after accept", {31'b0, req_ready}, 32'd0);
        req_op = 2'b01; req_wdata = 32'h0BAD_0BAD;
        @(posedge clk);
        @(negedge clk);
        chk("R8 busy done", {31'b0, done}, 32'd1);
        chk("R8 first op data", wb0_data, 32'hA5A5_0001);
        req_valid = 1'b0;
        run_op(2'b00, 32'h0000_1008, 16'h0, 32'h0, 5'd5, 5'd6);
        chk("R8 busy store ignored", o_d0, 32'hA5A5_0001);
    endtask

    task automatic t_reserved;
        run_op(2'b11, 32'h0000_1008, 16'h0, 32'hFFFF_0000, 5'd5, 5'd6);
        chk("R11 done no flag", {30'b0, o_done, o_mis}, 32'd2);
        chk("R11 no wb", {30'b0, o_en0, o_en1}, 32'd0);
        run_op(2'b00, 32'h0000_1008, 16'h0, 32'h0, 5'd5, 5'd6);
        chk("R11 memory untouched", o_d0, 32'hA5A5_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_load();
        t_autoupdate_walk();
        t_zero_reg();
        t_same_reg();
        t_misalign();
        t_alias_wrap();
        t_busy();
        t_reserved();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule